// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a small serial memory. It watches an externally pulled-up two-wire bus through its serial clock and data inputs. Both inputs are resynchronised to an oversampling system clock. The block finds start and stop conditions, takes in a device-select byte, a word address and any number of write bytes, and acknowledges each one by pulling the data line low on the ninth clock. A storage controller sits behind it. That controller gets a word address, a one-cycle strobe for each write byte, a one-cycle request before each read byte, and a pulse for each stop condition.

For reads, the block loads a byte from the controller and shifts it out most significant bit first. The line is released for a 1 and pulled for a 0. A master acknowledge asks for the next byte. A master not-acknowledge ends the output. The density option `WIDE_ARRAY` selects the device variant. The 256-byte variant compares three pin inputs against the select byte. The 512-byte variant compares only two pins and takes the remaining select bit as the ninth word-address bit.

Top module: `twi_mem_front`

## Requirements
- R1: After reset, `sda_pull_o`, `wr_strobe_o`, `rd_req_o` and `stop_o` are 0 and `word_addr_o` is 0.
- R2: Every stop condition (data rising while the clock is high) gives exactly one one-cycle `stop_o` pulse and releases the line. A start condition (data falling while the clock is high) at any point, even in the middle of a byte, drops the current byte and restarts select-byte reception.
- R3: A select byte matches only when bits [7:4] equal 4'b1010 and the address field matches. With `WIDE_ARRAY`=0, bits [3:1] must equal `dev_pins_i[2:0]`. With `WIDE_ARRAY`=1, bits [3:2] must equal `dev_pins_i[2:1]`, and bit 1 becomes word-address bit 8. A match is acknowledged (line low on the ninth clock). A mismatch leaves the line released for that byte and for every byte until the next start.
- R4: Bits are captured on the rising serial clock, most significant bit first. The block only begins pulling the line while the synchronised clock is low.
- R5: After a matched select byte with bit 0 = 0 (write), the next byte is acknowledged and loaded into word-address bits [7:0].
- R6: Each further write byte is acknowledged and produces one `wr_strobe_o` pulse, with the byte on `wr_data_o` and its address on `word_addr_o`. The address then advances by one.
- R7: The word address wraps from the top of the array to 0 (255 with `WIDE_ARRAY`=0, 511 with `WIDE_ARRAY`=1).
- R8: After a matched select byte with bit 0 = 1 (read), the block acknowledges and pulses `rd_req_o` at the end of the acknowledge. It samples `rd_data_i` one clock later and shifts it out. The address advances by one after each byte sent.
- R9: A master acknowledge (0) on the ninth clock of a read byte starts another `rd_req_o` and byte. A not-acknowledge (1) ends the output: the line stays released until the next start.
- R10: `sda_pull_o`=1 means the block pulls the line low. The block never pulls while the master is sending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus) |
| dev_pins_i | input | 3 | Hardwired device address pins |
| rd_data_i | input | 8 | Read byte from the storage controller at `word_addr_o` |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| word_addr_o | output | AW (8, or 9 when WIDE_ARRAY=1) | Current word address |
| wr_strobe_o | output | 1 | One-cycle write-byte strobe |
| wr_data_o | output | 8 | Write byte, valid with the strobe |
| rd_req_o | output | 1 | One-cycle request for the next read byte |
| stop_o | output | 1 | One-cycle pulse per stop condition |

## Verification
The hardest situations to reach from the ports are a start condition that lands in the middle of a byte, and the state after a master not-acknowledge. In both, the block must drop what it holds without leaving the line pulled. The bench puts a 256-byte and a 512-byte instance on one shared wired bus. It drives partial bytes followed by a repeated start, and it clocks a whole extra byte after a not-acknowledge, which must read back as all ones. On every clock while the master is sending, it checks that neither slave pulls the line. Address wrap at both array sizes and the ninth address bit taken from the select byte are also covered.

// File: rtl/twi_front_pkg.sv
package twi_front_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_LOAD,
    ST_TX,
    ST_MACK
  } front_state_e;

  typedef enum logic [1:0] {
    RX_SEL,
    RX_ADDR,
    RX_DATA
  } rx_kind_e;

  localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES:0] chain;

  assign chain[0] = d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain[i+1] <= 1'b1;
      end else begin
        chain[i+1] <= chain[i];
      end
    end
  end

  assign q = chain[STAGES];

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_sel_match.sv
module twi_sel_match
  import twi_front_pkg::*;
#(
  parameter bit WIDE = 1'b0,
  parameter int AW   = 8
) (
  input  logic [7:1]    sel_i,
  input  logic [2:0]    pins_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [AW-1:0] addr_o
);

  if (WIDE) begin : g_wide
    logic pin0_unused;
    assign pin0_unused = pins_i[0];
    assign hit_o  = (sel_i[7:4] == DEV_TYPE_CODE) && (sel_i[3:2] == pins_i[2:1]);
    assign addr_o = {sel_i[1], addr_i[AW-2:0]};
  end else begin : g_narrow
    assign hit_o  = (sel_i[7:4] == DEV_TYPE_CODE) && (sel_i[3:1] == pins_i);
    assign addr_o = addr_i;
  end

endmodule

// File: rtl/twi_mem_front.sv
module twi_mem_front
  import twi_front_pkg::*;
#(
  parameter bit WIDE_ARRAY  = 1'b0,
  parameter int SYNC_STAGES = 2,
  localparam int AW = WIDE_ARRAY ? 9 : 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    dev_pins_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_pull_o,
  output logic [AW-1:0] word_addr_o,
  output logic          wr_strobe_o,
  output logic [7:0]    wr_data_o,
  output logic          rd_req_o,
  output logic          stop_o
);

  localparam int WORD_BITS = 8;
  localparam int CW        = $clog2(WORD_BITS + 1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic sel_hit;
  logic [AW-1:0] sel_addr;

  front_state_e state_q, state_n;
  rx_kind_e     kind_q, kind_n;
  logic [CW-1:0]        cnt_q, cnt_n;
  logic [WORD_BITS-1:0] shreg_q, shreg_n;
  logic [WORD_BITS-1:0] wdata_q, wdata_n;
  logic [AW-1:0]        addr_q, addr_n;
  logic rnw_q, rnw_n;
  logic mnack_q, mnack_n;
  logic wstb_q, wstb_n;
  logic rreq_q, rreq_n;
  logic stop_q, stop_n;
  logic pull_q, pull_n;

  twi_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
  );

  twi_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
  );

  twi_cond_detect u_det (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_sel_match #(.WIDE(WIDE_ARRAY), .AW(AW)) u_match (
    .sel_i(shreg_q[7:1]), .pins_i(dev_pins_i), .addr_i(addr_q),
    .hit_o(sel_hit), .addr_o(sel_addr)
  );

  // Next-state logic
  always_comb begin
    state_n = state_q;
    kind_n  = kind_q;
    cnt_n   = cnt_q;
    shreg_n = shreg_q;
    rnw_n   = rnw_q;
    addr_n  = addr_q;
    wdata_n = wdata_q;
    mnack_n = mnack_q;
    wstb_n  = 1'b0;
    rreq_n  = 1'b0;
    stop_n  = 1'b0;

    // advance past a byte that was just written
    if (wstb_q) addr_n = addr_q + 1'b1;

    unique case (state_q)
      ST_IDLE: begin
      end
      ST_RX: begin
        if (scl_rise && cnt_q != CW'(WORD_BITS)) begin
          shreg_n = {shreg_q[WORD_BITS-2:0], sda_s};
          cnt_n   = cnt_q + 1'b1;
        end else if (scl_fall && cnt_q == CW'(WORD_BITS)) begin
          state_n = ST_ACK;
          unique case (kind_q)
            RX_SEL: begin
              if (sel_hit) begin
                rnw_n  = shreg_q[0];
                addr_n = sel_addr;
              end else begin
                state_n = ST_IDLE;
              end
            end
            RX_ADDR: addr_n[WORD_BITS-1:0] = shreg_q;
            default: begin
              wstb_n  = 1'b1;
              wdata_n = shreg_q;
            end
          endcase
        end
      end
      ST_ACK: begin
        if (scl_fall) begin
          if (kind_q == RX_SEL && rnw_q) begin
            state_n = ST_LOAD;
            rreq_n  = 1'b1;
          end else begin
            state_n = ST_RX;
            cnt_n   = '0;
            kind_n  = (kind_q == RX_SEL) ? RX_ADDR : RX_DATA;
          end
        end
      end
      ST_LOAD: begin
        shreg_n = rd_data_i;
        cnt_n   = '0;
        state_n = ST_TX;
      end
      ST_TX: begin
        if (scl_fall) begin
          shreg_n = {shreg_q[WORD_BITS-2:0], 1'b1};
          cnt_n   = cnt_q + 1'b1;
          if (cnt_q == CW'(WORD_BITS - 1)) begin
            state_n = ST_MACK;
            addr_n  = addr_q + 1'b1;
          end
        end
      end
      ST_MACK: begin
        if (scl_rise) mnack_n = sda_s;
        if (scl_fall) begin
          if (mnack_q) begin
            state_n = ST_IDLE;
          end else begin
            state_n = ST_LOAD;
            rreq_n  = 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase

    if (start_det) begin
      state_n = ST_RX;
      kind_n  = RX_SEL;
      cnt_n   = '0;
    end
    if (stop_det) begin
      state_n = ST_IDLE;
      stop_n  = 1'b1;
    end

    pull_n = (state_n == ST_ACK) ||
             (state_n == ST_TX && !shreg_n[WORD_BITS-1]);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= RX_SEL;
      cnt_q   <= '0;
      shreg_q <= '0;
      wdata_q <= '0;
      addr_q  <= '0;
      rnw_q   <= 1'b0;
      mnack_q <= 1'b0;
      wstb_q  <= 1'b0;
      rreq_q  <= 1'b0;
      stop_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      kind_q  <= kind_n;
      cnt_q   <= cnt_n;
      shreg_q <= shreg_n;
      rnw_q   <= rnw_n;
      mnack_q <= mnack_n;
      wstb_q  <= wstb_n;
      rreq_q  <= rreq_n;
      stop_q  <= stop_n;
      pull_q  <= pull_n;
      addr_q  <= addr_n;
      if (wstb_n) wdata_q <= wdata_n;
    end
  end

  assign sda_pull_o  = pull_q;
  assign word_addr_o = addr_q;
  assign wr_strobe_o = wstb_q;
  assign wr_data_o   = wdata_q;
  assign rd_req_o    = rreq_q;
  assign stop_o      = stop_q;

endmodule

// File: rtl/twi_mem_front_chk.sv
module twi_mem_front_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_pull_o,
  input logic [AW-1:0] word_addr_o,
  input logic          wr_strobe_o,
  input logic          rd_req_o,
  input logic          stop_o
);

  // R6: a write strobe lasts a single cycle
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |=> !wr_strobe_o);

  // R6, R7: address advances by one (wrapping) after each write byte
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |=> (word_addr_o == $past(word_addr_o) + 1'b1));

  // R8: read request lasts a single cycle
  a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);

  // R4: pulling starts only while the synchronised clock is low
  a_r4_pull_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);

  // R2: the line is free when a stop is reported
  a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> !sda_pull_o);

  // R2: stop, write strobe and read request never coincide
  a_r2_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_strobe_o, rd_req_o, stop_o}));

endmodule

bind twi_mem_front twi_mem_front_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
  .word_addr_o(word_addr_o), .wr_strobe_o(wr_strobe_o),
  .rd_req_o(rd_req_o), .stop_o(stop_o)
);

// File: tb/twi_mem_front_tb_top.sv
module twi_mem_front_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic quiet = 1'b0;
  logic sda;

  logic       pull_n, pull_w;
  logic [7:0] addr_n;
  logic [8:0] addr_w;
  logic       stb_n, stb_w, req_n, req_w, stp_n, stp_w;
  logic [7:0] wd_n, wd_w, rd_n, rd_w;

  logic [7:0] mem_n [256];
  logic [7:0] mem_w [512];
  logic [7:0] ref_n [256];
  logic [7:0] ref_w [512];
  logic [15:0] q_n [$];
  logic [16:0] q_w [$];

  int n_checks = 0;
  int n_fail = 0;
  int c_stb_n = 0, c_stb_w = 0, c_req_n = 0, c_req_w = 0, c_stp_n = 0, c_stp_w = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda  = !(!m_sda || pull_n || pull_w);
  assign rd_n = mem_n[addr_n];
  assign rd_w = mem_w[addr_w];

  twi_mem_front #(.WIDE_ARRAY(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda),
    .dev_pins_i(3'b000), .rd_data_i(rd_n), .sda_pull_o(pull_n),
    .word_addr_o(addr_n), .wr_strobe_o(stb_n), .wr_data_o(wd_n),
    .rd_req_o(req_n), .stop_o(stp_n)
  );

  twi_mem_front #(.WIDE_ARRAY(1'b1)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda),
    .dev_pins_i(3'b010), .rd_data_i(rd_w), .sda_pull_o(pull_w),
    .word_addr_o(addr_w), .wr_strobe_o(stb_w), .wr_data_o(wd_w),
    .rd_req_o(req_w), .stop_o(stp_w)
  );

  function automatic void check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  // Storage model and per-clock observation
  always @(negedge clk) begin
    if (rst_n) begin
      if (quiet) check(!(pull_n || pull_w), "R10 no pull while master sends", {pull_n, pull_w}, 0);
      if (stb_n) begin
        c_stb_n++;
        mem_n[addr_n] = wd_n;
        if (q_n.size() == 0) check(0, "R6 unexpected narrow strobe", {addr_n, wd_n}, 0);
        else begin
          logic [15:0] e;
          e = q_n.pop_front();
          check({addr_n, wd_n} == e, "R6 narrow strobe addr/data", {addr_n, wd_n}, e);
        end
      end
      if (stb_w) begin
        c_stb_w++;
        mem_w[addr_w] = wd_w;
        if (q_w.size() == 0) check(0, "R6 unexpected wide strobe", {addr_w, wd_w}, 0);
        else begin
          logic [16:0] e;
          e = q_w.pop_front();
          check({addr_w, wd_w} == e, "R6 wide strobe addr/data", {addr_w, wd_w}, e);
        end
      end
      if (req_n) c_req_n++;
      if (req_w) c_req_w++;
      if (stp_n) c_stp_n++;
      if (stp_w) c_stp_w++;
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    wq();
    quiet = 1'b1;
    m_sda = b; wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0;
    quiet = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wq(); wq();
    m_scl = 1'b1; wq();
    b = sda; wq();
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(ack);
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(!master_ack);
  endtask

  task automatic exp_n(input logic [7:0] a, input logic [7:0] d);
    q_n.push_back({a, d});
    ref_n[a] = d;
  endtask

  task automatic exp_w(input logic [8:0] a, input logic [7:0] d);
    q_w.push_back({a, d});
    ref_w[a] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] v;
    int         base;
    for (int i = 0; i < 256; i++) begin mem_n[i] = 8'h00; ref_n[i] = 8'h00; end
    for (int i = 0; i < 512; i++) begin mem_w[i] = 8'h00; ref_w[i] = 8'h00; end

    repeat (5) @(negedge clk);
    // R1: reset state
    check(!pull_n && !pull_w, "R1 pull after reset", {pull_n, pull_w}, 0);
    check(!stb_n && !req_n && !stp_n, "R1 strobes after reset", {stb_n, req_n, stp_n}, 0);
    check(addr_n == 0 && addr_w == 0, "R1 address after reset", {addr_w, addr_n}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3, R5, R6: narrow write of two bytes at 0x10
    exp_n(8'h10, 8'hA5); exp_n(8'h11, 8'h3C);
    base = c_stp_n;
    bus_start();
    send_byte(8'hA0, ack); check(ack == 0, "R3 narrow select ack", ack, 0);
    send_byte(8'h10, ack); check(ack == 0, "R5 address ack", ack, 0);
    send_byte(8'hA5, ack); check(ack == 0, "R6 data ack", ack, 0);
    send_byte(8'h3C, ack); check(ack == 0, "R6 data ack 2", ack, 0);
    bus_stop();
    check(c_stp_n == base + 1, "R2 one stop pulse", c_stp_n - base, 1);
    check(c_stb_n == 2, "R6 narrow strobe count", c_stb_n, 2);
    check(addr_n == 8'h12, "R6 address advanced", addr_n, 8'h12);

    // R8, R9: random read with master ack then nack, then released byte
    base = c_req_n;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h10, ack);
    bus_start();
    send_byte(8'hA1, ack); check(ack == 0, "R8 read select ack", ack, 0);
    recv_byte(1'b1, v); check(v == ref_n[8'h10], "R8 read byte 0", v, ref_n[8'h10]);
    recv_byte(1'b0, v); check(v == ref_n[8'h11], "R9 read after master ack", v, ref_n[8'h11]);
    recv_byte(1'b0, v); check(v == 8'hFF, "R9 released after nack", v, 8'hFF);
    bus_stop();
    check(c_req_n - base == 2, "R9 read requests", c_req_n - base, 2);
    check(addr_n == 8'h12, "R8 address after reads", addr_n, 8'h12);

    // R3: mismatched address field, then ignored bytes
    bus_start();
    send_byte(8'hAE, ack); check(ack == 1, "R3 pin mismatch nack", ack, 1);
    send_byte(8'h55, ack); check(ack == 1, "R3 ignored byte nack", ack, 1);
    send_byte(8'h66, ack); check(ack == 1, "R3 ignored byte nack 2", ack, 1);
    bus_stop();
    // R3: wrong device type code
    bus_start();
    send_byte(8'hB0, ack); check(ack == 1, "R3 type code mismatch", ack, 1);
    bus_stop();
    check(c_stb_n == 2 && c_stb_w == 0, "R3 no strobes on mismatch", c_stb_n + c_stb_w, 2);
    check(c_stp_w == 4, "R2 wide stop count", c_stp_w, 4);

    // R3: wide variant, page bit from select bit 1
    exp_w(9'h105, 8'h77);
    exp_w(9'h005, 8'h11);
    bus_start();
    send_byte(8'hA6, ack); check(ack == 0, "R3 wide select ack", ack, 0);
    send_byte(8'h05, ack);
    send_byte(8'h77, ack);
    bus_stop();
    bus_start();
    send_byte(8'hA4, ack);
    send_byte(8'h05, ack);
    send_byte(8'h11, ack);
    bus_stop();
    bus_start();
    send_byte(8'hA6, ack);
    send_byte(8'h05, ack);
    bus_start();
    send_byte(8'hA7, ack); check(ack == 0, "R8 wide read select ack", ack, 0);
    recv_byte(1'b0, v); check(v == 8'h77, "R3 wide upper page read", v, 8'h77);
    bus_stop();
    check(addr_w == 9'h106, "R8 wide address after read", addr_w, 9'h106);
    bus_start();
    send_byte(8'hA4, ack);
    send_byte(8'h05, ack);
    bus_start();
    send_byte(8'hA5, ack);
    recv_byte(1'b0, v); check(v == 8'h11, "R3 wide lower page read", v, 8'h11);
    bus_stop();

    // R2: start in the middle of a byte aborts it
    exp_n(8'h20, 8'h5A);
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(8'hA0, ack); check(ack == 0, "R2 select after restart", ack, 0);
    send_byte(8'h20, ack);
    send_byte(8'h5A, ack);
    bus_stop();
    check(c_stb_n == 3, "R2 one strobe after abort", c_stb_n, 3);

    // R7: wrap at both array sizes
    exp_n(8'hFF, 8'h01); exp_n(8'h00, 8'h02);
    bus_start();
    send_byte(8'hA0, ack); send_byte(8'hFF, ack);
    send_byte(8'h01, ack); send_byte(8'h02, ack);
    bus_stop();
    check(addr_n == 8'h01, "R7 narrow wrap", addr_n, 8'h01);
    exp_w(9'h1FF, 8'h09); exp_w(9'h000, 8'h0A);
    bus_start();
    send_byte(8'hA6, ack); send_byte(8'hFF, ack);
    send_byte(8'h09, ack); send_byte(8'h0A, ack);
    bus_stop();
    check(addr_w == 9'h001, "R7 wide wrap", addr_w, 9'h001);

    // R4: MSB-first capture read back across the wrap
    bus_start();
    send_byte(8'hA0, ack); send_byte(8'hFF, ack);
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b1, v); check(v == 8'h01, "R4 read at top", v, 8'h01);
    recv_byte(1'b0, v); check(v == 8'h02, "R7 read after wrap", v, 8'h02);
    bus_stop();

    repeat (10) @(negedge clk);
    check(q_n.size() == 0 && q_w.size() == 0, "R6 all expected writes seen",
          q_n.size() + q_w.size(), 0);
    check(!pull_n && !pull_w, "R9 idle release", {pull_n, pull_w}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule